// File: doc/BRIEF.md
# Dual-Channel Sample Output Demultiplexer with Forwarded DDR Clock

This block sits between the two conversion channels (I and Q) and their output pins. On every cycle of the sampling clock each channel delivers one 12-bit sample with its out-of-range flag. The block places these samples on the output buses in one of two ways. In full-rate mode the primary bus of each channel carries every sample and the secondary (delayed) bus is switched off. In split mode samples are paired, and both buses update together every second cycle: the secondary bus carries the earlier sample and the primary bus carries the later one.

A forwarded data clock goes with each channel, and the receiver captures data on both of its edges. In split mode it runs at one quarter of the sampling clock and can be edge-aligned with the data or shifted so that each edge falls in the middle of the data eye. In full-rate mode it runs at one half of the sampling clock and is always edge-aligned. Both channels share one phase divider, so their clocks stay identical unless a channel is powered down. A synchronous realignment pulse puts the divider back to a known phase.

The sample inputs form a fixed-rate stream with no back-pressure. One sample per channel is accepted on every clock edge, with no valid or ready handshake, because a converter cannot stall. The secondary bus's high-impedance state is represented by an output enable that the pad ring uses.

Top module: `sample_demux_ddr`

## Requirements
- R1: In full-rate mode (`split_mode`=0), after every clock edge the primary bus and its flag of a powered channel equal the sample and flag presented at that edge.
- R2: In full-rate mode the secondary-bus enable of each channel is 0 and its data and flag are driven 0.
- R3: In split mode the divider phase counts 0,1,2,3 and repeats. A sample taken at an even phase is held. At the following odd-phase edge the primary bus takes the current sample and the secondary bus takes the held one. Both buses stay unchanged at the even-phase edges, and the secondary-bus enable is 1.
- R4: Bit 12 of each bus word is the out-of-range flag of exactly the sample carried in bits 11:0, on both the primary and the secondary bus.
- R5: In split mode with `dclk_ph90`=0, the data clock is 1 after the edges at phases 1 and 2 and 0 after the edges at phases 3 and 0. It therefore changes in the same cycle as the data, with a period of four clocks.
- R6: In split mode with `dclk_ph90`=1, the data clock is 1 after the edges at phases 2 and 3 and 0 otherwise. Each of its transitions falls one cycle after a data change.
- R7: In full-rate mode the data clock is 1 after edges at even phases and 0 after odd phases, so it toggles every cycle. `dclk_ph90` has no effect.
- R8: An edge with `dclk_rst`=1 forces the phase to 0, drives both data clocks to 0 and loads no pair. The first sample taken after release becomes the secondary (earlier) sample of the first pair.
- R9: While a channel's power-down input is 1, its bus words are 0 and its enable and data clock are 0. The other channel is unaffected. When both channels are powered, `dclk_i` equals `dclk_q` after every edge.
- R10: While `rst_n` is 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dclk_rst | input | 1 | Synchronous divider realignment pulse |
| split_mode | input | 1 | 1 = paired two-bus mode, 0 = full-rate single bus |
| dclk_ph90 | input | 1 | 1 = mid-eye data clock placement (split mode only) |
| pd_i | input | 1 | Power down I channel |
| pd_q | input | 1 | Power down Q channel |
| i_data | input | 12 | I sample |
| i_ovr | input | 1 | I out-of-range flag |
| q_data | input | 12 | Q sample |
| q_ovr | input | 1 | Q out-of-range flag |
| i_bus | output | 12 | I primary bus (later sample) |
| i_bus_ovr | output | 1 | Flag for `i_bus` |
| i_dly | output | 12 | I secondary bus (earlier sample) |
| i_dly_ovr | output | 1 | Flag for `i_dly` |
| i_dly_oe | output | 1 | I secondary bus drive enable |
| q_bus | output | 12 | Q primary bus |
| q_bus_ovr | output | 1 | Flag for `q_bus` |
| q_dly | output | 12 | Q secondary bus |
| q_dly_ovr | output | 1 | Flag for `q_dly` |
| q_dly_oe | output | 1 | Q secondary bus drive enable |
| dclk_i | output | 1 | I forwarded data clock |
| dclk_q | output | 1 | Q forwarded data clock |

## Verification
A realignment pulse can arrive in the same cycle in which a pair is in progress and the data clock is high. The bench provokes this by raising `dclk_rst` at phase 2 of a split-mode run. It then checks that the clock drops at once, that the pair already on the buses is kept, and that the next pair is built from the two samples after release rather than from the sample before the pulse. A power-down of one channel is also made to coincide with a pair boundary. The bench judges it by the other channel's clock and by the two clocks matching after power-up.

// File: rtl/sample_demux_pkg.sv
`timescale 1ns/1ps
package sample_demux_pkg;
  localparam int PHASE_W = 2;
  typedef logic [PHASE_W-1:0] phase_t;
  typedef enum logic {LAYOUT_FULL = 1'b0, LAYOUT_SPLIT = 1'b1} layout_e;
endpackage

// File: rtl/sample_demux_phase.sv
`timescale 1ns/1ps
module sample_demux_phase
  import sample_demux_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic realign,
  input  logic split,
  input  logic ph90,
  output logic take_first,
  output logic take_pair,
  output logic dclk_nxt
);
  phase_t  phase;
  layout_e layout;

  assign layout = split ? LAYOUT_SPLIT : LAYOUT_FULL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (realign) phase <= '0;
    else              phase <= phase + 1'b1;
  end

  assign take_first = ~phase[0];
  assign take_pair  = (layout == LAYOUT_SPLIT) && phase[0] && !realign;

  always_comb begin
    if (realign)                     dclk_nxt = 1'b0;
    else if (layout == LAYOUT_SPLIT) dclk_nxt = ph90 ? phase[1] : (phase[1] ^ phase[0]);
    else                             dclk_nxt = ~phase[0];
  end
endmodule

// File: rtl/sample_demux_lane.sv
`timescale 1ns/1ps
module sample_demux_lane #(
  parameter int WORD_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              split,
  input  logic              pd,
  input  logic              take_first,
  input  logic              take_pair,
  input  logic              dclk_nxt,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] pri,
  output logic [WORD_W-1:0] dly,
  output logic              dly_oe,
  output logic              dclk
);
  logic [WORD_W-1:0] early;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          early <= '0;
    else if (take_first) early <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri    <= '0;
      dly    <= '0;
      dly_oe <= 1'b0;
      dclk   <= 1'b0;
    end else if (pd) begin
      pri    <= '0;
      dly    <= '0;
      dly_oe <= 1'b0;
      dclk   <= 1'b0;
    end else if (split) begin
      if (take_pair) begin
        pri <= din;
        dly <= early;
      end
      dly_oe <= 1'b1;
      dclk   <= dclk_nxt;
    end else begin
      pri    <= din;
      dly    <= '0;
      dly_oe <= 1'b0;
      dclk   <= dclk_nxt;
    end
  end
endmodule

// File: rtl/sample_demux_ddr.sv
`timescale 1ns/1ps
module sample_demux_ddr #(
  parameter int DATA_W = 12,
  parameter int N_CH   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dclk_rst,
  input  logic              split_mode,
  input  logic              dclk_ph90,
  input  logic              pd_i,
  input  logic              pd_q,
  input  logic [DATA_W-1:0] i_data,
  input  logic              i_ovr,
  input  logic [DATA_W-1:0] q_data,
  input  logic              q_ovr,
  output logic [DATA_W-1:0] i_bus,
  output logic              i_bus_ovr,
  output logic [DATA_W-1:0] i_dly,
  output logic              i_dly_ovr,
  output logic              i_dly_oe,
  output logic [DATA_W-1:0] q_bus,
  output logic              q_bus_ovr,
  output logic [DATA_W-1:0] q_dly,
  output logic              q_dly_ovr,
  output logic              q_dly_oe,
  output logic              dclk_i,
  output logic              dclk_q
);
  localparam int WORD_W = DATA_W + 1;

  logic take_first, take_pair, dclk_nxt;
  logic [WORD_W-1:0] din_w [N_CH];
  logic [WORD_W-1:0] pri_w [N_CH];
  logic [WORD_W-1:0] dly_w [N_CH];
  logic [N_CH-1:0]   pd_w, oe_w, dclk_w;

  sample_demux_phase u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .realign    (dclk_rst),
    .split      (split_mode),
    .ph90       (dclk_ph90),
    .take_first (take_first),
    .take_pair  (take_pair),
    .dclk_nxt   (dclk_nxt)
  );

  assign din_w[0] = {i_ovr, i_data};
  assign din_w[1] = {q_ovr, q_data};
  assign pd_w     = {pd_q, pd_i};

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_lane
    sample_demux_lane #(.WORD_W(WORD_W)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .split      (split_mode),
      .pd         (pd_w[ch]),
      .take_first (take_first),
      .take_pair  (take_pair),
      .dclk_nxt   (dclk_nxt),
      .din        (din_w[ch]),
      .pri        (pri_w[ch]),
      .dly        (dly_w[ch]),
      .dly_oe     (oe_w[ch]),
      .dclk       (dclk_w[ch])
    );
  end

  assign {i_bus_ovr, i_bus} = pri_w[0];
  assign {i_dly_ovr, i_dly} = dly_w[0];
  assign {q_bus_ovr, q_bus} = pri_w[1];
  assign {q_dly_ovr, q_dly} = dly_w[1];
  assign i_dly_oe = oe_w[0];
  assign q_dly_oe = oe_w[1];
  assign dclk_i   = dclk_w[0];
  assign dclk_q   = dclk_w[1];
endmodule

// File: rtl/sample_demux_checker.sv
`timescale 1ns/1ps
module sample_demux_checker #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dclk_rst,
  input logic              split_mode,
  input logic              pd_i,
  input logic              pd_q,
  input logic [DATA_W-1:0] i_data,
  input logic              i_ovr,
  input logic [DATA_W-1:0] i_bus,
  input logic              i_bus_ovr,
  input logic [DATA_W-1:0] i_dly,
  input logic              i_dly_oe,
  input logic              q_dly_oe,
  input logic              dclk_i,
  input logic              dclk_q
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_full_rate_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!split_mode && !pd_i) |-> ({i_bus_ovr, i_bus} == $past({i_ovr, i_data})));

  assert_dly_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!split_mode) |-> (!i_dly_oe && !q_dly_oe && i_dly == '0));

  assert_realign_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(dclk_rst) |-> (!dclk_i && !dclk_q));

  assert_pd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(pd_i) |-> (!dclk_i && !i_dly_oe && i_bus == '0));

  assert_clocks_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!pd_i && !pd_q) |-> (dclk_i == dclk_q));
endmodule

bind sample_demux_ddr sample_demux_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dclk_rst   (dclk_rst),
  .split_mode (split_mode),
  .pd_i       (pd_i),
  .pd_q       (pd_q),
  .i_data     (i_data),
  .i_ovr      (i_ovr),
  .i_bus      (i_bus),
  .i_bus_ovr  (i_bus_ovr),
  .i_dly      (i_dly),
  .i_dly_oe   (i_dly_oe),
  .q_dly_oe   (q_dly_oe),
  .dclk_i     (dclk_i),
  .dclk_q     (dclk_q)
);

// File: tb/sample_demux_ddr_tb.sv
`timescale 1ns/1ps
module sample_demux_ddr_tb;
  logic clk = 1'b0;
  logic rst_n, dclk_rst, split_mode, dclk_ph90, pd_i, pd_q;
  logic [11:0] i_data, q_data, i_bus, i_dly, q_bus, q_dly;
  logic i_ovr, q_ovr, i_bus_ovr, i_dly_ovr, q_bus_ovr, q_dly_ovr;
  logic i_dly_oe, q_dly_oe, dclk_i, dclk_q;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sample_demux_ddr u_dut (.*);

  // row: split, ph90, i_in, q_in, i_pri, i_dly, q_pri, q_dly, oe, dclk
  localparam int ROWS = 12;
  localparam logic [81:0] VEC [ROWS] = '{
    {1'b1,1'b0,13'h00A1,13'h0011,13'h0000,13'h0000,13'h0000,13'h0000,1'b1,1'b0},
    {1'b1,1'b0,13'h1FFF,13'h0022,13'h1FFF,13'h00A1,13'h0022,13'h0011,1'b1,1'b1},
    {1'b1,1'b0,13'h0123,13'h1033,13'h1FFF,13'h00A1,13'h0022,13'h0011,1'b1,1'b1},
    {1'b1,1'b0,13'h1800,13'h0044,13'h1800,13'h0123,13'h0044,13'h1033,1'b1,1'b0},
    {1'b1,1'b1,13'h0456,13'h0055,13'h1800,13'h0123,13'h0044,13'h1033,1'b1,1'b0},
    {1'b1,1'b1,13'h0789,13'h1066,13'h0789,13'h0456,13'h1066,13'h0055,1'b1,1'b0},
    {1'b1,1'b1,13'h1000,13'h0077,13'h0789,13'h0456,13'h1066,13'h0055,1'b1,1'b1},
    {1'b1,1'b1,13'h0ABC,13'h0088,13'h0ABC,13'h1000,13'h0088,13'h0077,1'b1,1'b1},
    {1'b0,1'b0,13'h1FFF,13'h0099,13'h1FFF,13'h0000,13'h0099,13'h0000,1'b0,1'b1},
    {1'b0,1'b0,13'h0001,13'h10AA,13'h0001,13'h0000,13'h10AA,13'h0000,1'b0,1'b0},
    {1'b0,1'b1,13'h0F0F,13'h00BB,13'h0F0F,13'h0000,13'h00BB,13'h0000,1'b0,1'b1},
    {1'b0,1'b1,13'h1555,13'h00CC,13'h1555,13'h0000,13'h00CC,13'h0000,1'b0,1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [12:0] iw, input logic [12:0] qw);
    {i_ovr, i_data} = iw;
    {q_ovr, q_data} = qw;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dclk_rst = 1'b0; split_mode = 1'b1; dclk_ph90 = 1'b0;
    pd_i = 1'b0; pd_q = 1'b0;
    drive(13'h1ABC, 13'h1DEF);
    repeat (3) @(negedge clk);
    chk({i_bus_ovr,i_bus,i_dly_ovr,i_dly,q_bus_ovr,q_bus,q_dly_ovr,q_dly} == '0, "R10 buses", {i_bus_ovr,i_bus}, 0);
    chk({i_dly_oe,q_dly_oe,dclk_i,dclk_q} == '0, "R10 enables/clocks", {i_dly_oe,q_dly_oe,dclk_i,dclk_q}, 0);
    rst_n = 1'b1; dclk_rst = 1'b1;
    repeat (2) @(negedge clk);
    dclk_rst = 1'b0;

    // table walk: R5 rows 0-3, R6 rows 4-7, R7 rows 8-11
    for (int r = 0; r < ROWS; r++) begin
      logic [81:0] v;
      string dtag, ctag;
      v = VEC[r];
      split_mode = v[81]; dclk_ph90 = v[80];
      drive(v[79:67], v[66:54]);
      @(negedge clk);
      dtag = v[81] ? "R3 R4 data" : "R1 R4 data";
      ctag = (r < 4) ? "R5 dclk" : (r < 8) ? "R6 dclk" : "R7 dclk";
      chk({i_bus_ovr,i_bus} == v[53:41], dtag, {i_bus_ovr,i_bus}, v[53:41]);
      chk({i_dly_ovr,i_dly} == v[40:28], v[81] ? "R3 R4 i_dly" : "R2 i_dly", {i_dly_ovr,i_dly}, v[40:28]);
      chk({q_bus_ovr,q_bus} == v[27:15], dtag, {q_bus_ovr,q_bus}, v[27:15]);
      chk({q_dly_ovr,q_dly} == v[14:2], v[81] ? "R3 R4 q_dly" : "R2 q_dly", {q_dly_ovr,q_dly}, v[14:2]);
      chk(i_dly_oe == v[1] && q_dly_oe == v[1], v[81] ? "R3 oe" : "R2 oe", {i_dly_oe,q_dly_oe}, {v[1],v[1]});
      chk(dclk_i == v[0], ctag, dclk_i, v[0]);
      chk(dclk_q == v[0], "R9 dclk_q", dclk_q, v[0]);
    end

    // realignment in the middle of a pair, phase now 0
    split_mode = 1'b1; dclk_ph90 = 1'b0;
    drive(13'h0111, 13'h0211); @(negedge clk);
    drive(13'h1122, 13'h0222); @(negedge clk);
    chk({i_bus_ovr,i_bus} == 13'h1122 && {i_dly_ovr,i_dly} == 13'h0111, "R3 pair", {i_bus_ovr,i_bus}, 13'h1122);
    chk(dclk_i == 1'b1, "R5 dclk high", dclk_i, 1);
    dclk_rst = 1'b1; drive(13'h0333, 13'h0233); @(negedge clk);
    chk(!dclk_i && !dclk_q, "R8 realign clocks", {dclk_i,dclk_q}, 0);
    chk({i_bus_ovr,i_bus} == 13'h1122 && {i_dly_ovr,i_dly} == 13'h0111, "R8 pair kept", {i_bus_ovr,i_bus}, 13'h1122);
    dclk_rst = 1'b0; drive(13'h0444, 13'h0244); @(negedge clk);
    chk({i_bus_ovr,i_bus} == 13'h1122, "R8 no early load", {i_bus_ovr,i_bus}, 13'h1122);
    drive(13'h1555, 13'h0255); @(negedge clk);
    chk({i_bus_ovr,i_bus} == 13'h1555 && {i_dly_ovr,i_dly} == 13'h0444, "R8 first pair", {i_dly_ovr,i_dly}, 13'h0444);
    chk({q_bus_ovr,q_bus} == 13'h0255 && {q_dly_ovr,q_dly} == 13'h0244, "R8 q first pair", {q_dly_ovr,q_dly}, 13'h0244);
    chk(dclk_i == 1'b1, "R8 dclk after realign", dclk_i, 1);

    // power down I at phase 2
    pd_i = 1'b1; drive(13'h0666, 13'h0266); @(negedge clk);
    chk({i_bus_ovr,i_bus,i_dly_oe,dclk_i} == '0, "R9 pd quiet", {i_bus,i_dly_oe,dclk_i}, 0);
    chk(dclk_q == 1'b1 && {q_bus_ovr,q_bus} == 13'h0255, "R9 q unaffected", {dclk_q,q_bus}, {1'b1,12'h255});
    pd_i = 1'b0; drive(13'h0777, 13'h0277); @(negedge clk);
    chk(dclk_i == dclk_q && i_dly_oe, "R9 back in phase", {dclk_i,dclk_q}, {dclk_q,dclk_q});
    drive(13'h0888, 13'h0288); @(negedge clk);
    drive(13'h0999, 13'h0299); @(negedge clk);
    chk(dclk_i == 1'b1 && dclk_q == 1'b1, "R9 clocks match", {dclk_i,dclk_q}, 2'b11);
    chk({i_bus_ovr,i_bus} == 13'h0999 && {i_dly_ovr,i_dly} == 13'h0888, "R3 after pd", {i_bus_ovr,i_bus}, 13'h0999);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule